// File: doc/BRIEF.md
# Velocity-Sensing Key Matrix Scanner

This block reads a musical keyboard of up to 61 keys wired as an 8-by-8 matrix. Each key carries two contacts that close in turn as the key travels down. The scanner enables one column line at a time and reads two 8-bit return buses, one fed by the early contacts and one by the late contacts. The time between the two closures sets the strength of the note.

A scan column is held for a programmable settling time. The returns are then captured and the rows of that column are walked one per clock through a shared per-key state machine. That machine keeps an interval timer for each key. It produces note-on events that carry a transposed note number and a 7-bit strength code, and note-off events on release. Events leave through a small queue with a valid/ready handshake. If an event arrives while the queue is full, it is dropped and a sticky flag is raised. A strength-sensing enable can force a fixed strength on every note-on.

Top module: `velkey_scanner`

## Requirements
- R1: `scan_o` has exactly one bit high at any time. Column c is held for `dwell_i`+1+ROWS clocks, then column c+1 follows, wrapping from COLS-1 to 0.
- R2: The slot at column c and return bit r is key number c*ROWS+r. Slots numbered NUM_KEYS and above never produce an event.
- R3: The strength of a note-on is computed from T, the number of scans of that key that see only the early contact, not counting the scan that first saw it. T saturates at 2^TMR_W-1. The strength is 127-T when T is below that limit and 1 at the limit, so it is never 0.
- R4: While `touch_en_i` is low, every note-on carries the strength FIXED_VEL.
- R5: The note number is BASE_NOTE + key number + offset. The offset is `xpose_i` read as 4-bit two's complement and clamped to the range -6..+5.
- R6: A sounding key whose early contact is seen open emits one note-off: `ev_on_o`=0, the same note number rule, strength 0. The key then returns to idle.
- R7: No event is emitted in two cases. The first is an early contact that opens before the late contact closes. The second is a late contact that opens and closes again while the early contact stays closed.
- R8: Events leave in the order they were produced. One event is removed on each clock where `ev_valid_o` and `ev_ready_i` are both high. The queue holds DEPTH events.
- R9: An event produced while the queue is full and not being read is dropped. `ovf_o` then goes high and stays high until reset.
- R10: After reset, column 0 is driven, the queue is empty, `ovf_o` is low and every key is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dwell_i | input | DWELL_W | Extra settling clocks per column before capture |
| touch_en_i | input | 1 | High: measured strength; low: fixed strength |
| xpose_i | input | 4 | Signed semitone offset, clamped to -6..+5 |
| scan_o | output | COLS | One-hot column drive, active high |
| first_i | input | ROWS | Early-contact returns of the driven column |
| second_i | input | ROWS | Late-contact returns of the driven column |
| ev_valid_o | output | 1 | Event available |
| ev_ready_i | input | 1 | Consumer takes the event |
| ev_on_o | output | 1 | 1 = note-on, 0 = note-off |
| ev_note_o | output | 7 | Note number |
| ev_vel_o | output | 7 | Strength code (0 on note-off) |
| ovf_o | output | 1 | Sticky queue-overflow flag |

## Verification
The bench builds the scanner with TMR_W=4 and DEPTH=4 on the default 8-by-8 matrix. With TMR_W=4 the timer saturates after 15 counting scans, so the whole strength curve, including the floor at 1, can be swept scan by scan. With DEPTH=4, one column of eight keys struck together overfills the queue. The settling time is driven at 2 and 5 through `dwell_i` to time the columns. All 61 key slots are played in turn, and the three empty slots are pressed as well.

// File: rtl/vks_pkg.sv
package vks_pkg;
   typedef enum logic [1:0] {
      KS_IDLE,
      KS_FIRST,
      KS_ON,
      KS_REL
   } key_st_t;

   typedef struct packed {
      logic       on;
      logic [6:0] note;
      logic [6:0] vel;
   } key_evt_t;
endpackage

// File: rtl/vks_seq.sv
module vks_seq #(
   parameter int COLS    = 8,
   parameter int ROWS    = 8,
   parameter int DWELL_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DWELL_W-1:0]       dwell_i,
   output logic [COLS-1:0]          scan_o,
   output logic                     lat_o,
   output logic                     proc_o,
   output logic [$clog2(COLS)-1:0]  col_o,
   output logic [$clog2(ROWS)-1:0]  row_o
);
   localparam int COL_W = $clog2(COLS);
   localparam int ROW_W = $clog2(ROWS);

   logic [COL_W-1:0]   col_q;
   logic [ROW_W-1:0]   row_q;
   logic [DWELL_W-1:0] cnt_q;
   logic               rows_q;
   logic               row_last;

   assign row_last = (row_q == ROW_W'(ROWS - 1));
   assign lat_o    = !rows_q && (cnt_q == dwell_i);
   assign proc_o   = rows_q;
   assign col_o    = col_q;
   assign row_o    = row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         cnt_q  <= '0;
         rows_q <= 1'b0;
      end else if (!rows_q) begin
         if (cnt_q == dwell_i) begin
            cnt_q  <= '0;
            row_q  <= '0;
            rows_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (row_last) begin
         rows_q <= 1'b0;
         col_q  <= (col_q == COL_W'(COLS - 1)) ? '0 : col_q + 1'b1;
      end else begin
         row_q <= row_q + 1'b1;
      end
   end

   for (genvar c = 0; c < COLS; c++) begin : g_drive
      assign scan_o[c] = (col_q == COL_W'(c));
   end

   AST_SCAN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(scan_o) == 1); // R1

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rows_q && row_last) |=> (col_o == (($past(col_o) == COL_W'(COLS - 1)) ? '0 : $past(col_o) + 1'b1))); // R1
endmodule

// File: rtl/vks_keyproc.sv
module vks_keyproc
   import vks_pkg::*;
#(
   parameter int COLS      = 8,
   parameter int ROWS      = 8,
   parameter int NUM_KEYS  = 61,
   parameter int TMR_W     = 7,
   parameter int BASE_NOTE = 36,
   parameter int FIXED_VEL = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lat_i,
   input  logic                     proc_i,
   input  logic [$clog2(COLS)-1:0]  col_i,
   input  logic [$clog2(ROWS)-1:0]  row_i,
   input  logic [ROWS-1:0]          first_i,
   input  logic [ROWS-1:0]          second_i,
   input  logic                     touch_en_i,
   input  logic [3:0]               xpose_i,
   output logic                     push_o,
   output key_evt_t                 evt_o
);
   localparam int SLOTS = COLS * ROWS;
   localparam int KEY_W = $clog2(SLOTS);
   localparam logic [TMR_W-1:0] TMR_MAX = '1;

   key_st_t          st_q  [SLOTS];
   logic [TMR_W-1:0] tmr_q [SLOTS];
   logic [ROWS-1:0]  f_q, s_q;

   logic [KEY_W-1:0] key_sel;
   logic             is_key, f, s, is_on, emit;
   key_st_t          cur, nxt;
   logic [TMR_W-1:0] t, nt;
   logic signed [3:0] xs;
   logic signed [4:0] off;
   logic [6:0]       vel_meas;
   int               note_sum;

   assign key_sel = KEY_W'(col_i) * KEY_W'(ROWS) + KEY_W'(row_i);
   assign is_key  = proc_i && (int'(key_sel) < NUM_KEYS);
   assign f       = f_q[row_i];
   assign s       = s_q[row_i];
   assign cur     = st_q[key_sel];
   assign t       = tmr_q[key_sel];

   always_comb begin
      nxt   = cur;
      nt    = t;
      emit  = 1'b0;
      is_on = 1'b0;
      unique case (cur)
         KS_IDLE:  if (f) begin nxt = KS_FIRST; nt = '0; end
         KS_FIRST: begin
            if (!f) nxt = KS_IDLE;
            else if (s) begin nxt = KS_ON; emit = 1'b1; is_on = 1'b1; end
            else if (t != TMR_MAX) nt = t + 1'b1;
         end
         KS_ON: begin
            if (!f) begin nxt = KS_IDLE; emit = 1'b1; end
            else if (!s) nxt = KS_REL;
         end
         KS_REL: begin
            if (!f) begin nxt = KS_IDLE; emit = 1'b1; end
            else if (s) nxt = KS_ON;
         end
         default: nxt = KS_IDLE;
      endcase
   end

   always_comb begin
      xs = $signed(xpose_i);
      if (xs < -4'sd6)     off = -5'sd6;
      else if (xs > 4'sd5) off = 5'sd5;
      else                 off = {xs[3], xs};
   end

   assign note_sum = BASE_NOTE + int'(key_sel) + int'(off);
   assign vel_meas = (t == TMR_MAX) ? 7'd1 : 7'd127 - 7'(t);

   assign push_o     = is_key && emit;
   assign evt_o.on   = is_on;
   assign evt_o.note = 7'(note_sum);
   assign evt_o.vel  = !is_on ? 7'd0 : (touch_en_i ? vel_meas : 7'(FIXED_VEL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_q <= '0;
         s_q <= '0;
         for (int i = 0; i < SLOTS; i++) begin
            st_q[i]  <= KS_IDLE;
            tmr_q[i] <= '0;
         end
      end else begin
         if (lat_i) begin
            f_q <= first_i;
            s_q <= second_i;
         end
         if (is_key) begin
            st_q[key_sel]  <= nxt;
            tmr_q[key_sel] <= nt;
         end
      end
   end

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_i && cur == KS_IDLE) |-> !push_o); // R7

   AST_VEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && evt_o.on) |-> (evt_o.vel != 7'd0)); // R3

   AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_i && int'(key_sel) >= NUM_KEYS) |-> !push_o); // R2
endmodule

// File: rtl/vks_fifo.sv
module vks_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   input  logic         ready_i,
   output logic [W-1:0] data_o,
   output logic         ovf_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          full, pop, acc, ovf_q;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (cnt_q == CW'(DEPTH));
   assign valid_o = (cnt_q != '0);
   assign pop     = valid_o && ready_i;
   assign acc     = push_i && (!full || pop);
   assign data_o  = mem_q[rd_q];
   assign ovf_o   = ovf_q;

   always_ff @(posedge clk) begin
      if (acc) mem_q[wr_q] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (acc) wr_q <= step(wr_q);
         if (pop) rd_q <= step(rd_q);
         cnt_q <= cnt_q + CW'(acc) - CW'(pop);
         if (push_i && !acc) ovf_q <= 1'b1;
      end
   end

   AST_FILL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !full && !pop) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8

   AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !pop) |=> ovf_o); // R9

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o); // R9
endmodule

// File: rtl/velkey_scanner.sv
module velkey_scanner
   import vks_pkg::*;
#(
   parameter int COLS      = 8,
   parameter int ROWS      = 8,
   parameter int NUM_KEYS  = 61,
   parameter int TMR_W     = 7,
   parameter int DWELL_W   = 8,
   parameter int DEPTH     = 8,
   parameter int BASE_NOTE = 36,
   parameter int FIXED_VEL = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DWELL_W-1:0] dwell_i,
   input  logic               touch_en_i,
   input  logic [3:0]         xpose_i,
   output logic [COLS-1:0]    scan_o,
   input  logic [ROWS-1:0]    first_i,
   input  logic [ROWS-1:0]    second_i,
   output logic               ev_valid_o,
   input  logic               ev_ready_i,
   output logic               ev_on_o,
   output logic [6:0]         ev_note_o,
   output logic [6:0]         ev_vel_o,
   output logic               ovf_o
);
   localparam int COL_W = $clog2(COLS);
   localparam int ROW_W = $clog2(ROWS);
   localparam int EVT_W = $bits(key_evt_t);

   if (NUM_KEYS > COLS * ROWS || NUM_KEYS < 1) begin : g_bad_keys
      $error("velkey_scanner: NUM_KEYS does not fit the matrix");
   end
   if (TMR_W < 1 || TMR_W > 7) begin : g_bad_tmr
      $error("velkey_scanner: TMR_W must be 1..7");
   end
   if (BASE_NOTE < 6 || BASE_NOTE + NUM_KEYS + 4 > 127) begin : g_bad_base
      $error("velkey_scanner: note range leaves 0..127");
   end
   if (COLS < 2 || ROWS < 2 || DEPTH < 2) begin : g_bad_size
      $error("velkey_scanner: COLS, ROWS and DEPTH must be at least 2");
   end
   if (FIXED_VEL < 1 || FIXED_VEL > 127) begin : g_bad_fixed
      $error("velkey_scanner: FIXED_VEL must be 1..127");
   end

   logic             lat, proc, push;
   logic [COL_W-1:0] col;
   logic [ROW_W-1:0] row;
   key_evt_t         evt_in, evt_out;

   vks_seq #(.COLS(COLS), .ROWS(ROWS), .DWELL_W(DWELL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .dwell_i(dwell_i), .scan_o(scan_o),
      .lat_o(lat), .proc_o(proc), .col_o(col), .row_o(row)
   );

   vks_keyproc #(
      .COLS(COLS), .ROWS(ROWS), .NUM_KEYS(NUM_KEYS), .TMR_W(TMR_W),
      .BASE_NOTE(BASE_NOTE), .FIXED_VEL(FIXED_VEL)
   ) u_keys (
      .clk(clk), .rst_n(rst_n), .lat_i(lat), .proc_i(proc), .col_i(col),
      .row_i(row), .first_i(first_i), .second_i(second_i),
      .touch_en_i(touch_en_i), .xpose_i(xpose_i), .push_o(push), .evt_o(evt_in)
   );

   vks_fifo #(.DEPTH(DEPTH), .W(EVT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(evt_in),
      .valid_o(ev_valid_o), .ready_i(ev_ready_i), .data_o(evt_out), .ovf_o(ovf_o)
   );

   assign ev_on_o   = evt_out.on;
   assign ev_note_o = evt_out.note;
   assign ev_vel_o  = evt_out.vel;
endmodule

// File: tb/velkey_scanner_bench.sv
`timescale 1ns/1ps
module velkey_scanner_bench;
   localparam int TMR_W = 4;
   localparam int TMAX  = 15;
   localparam int BASE  = 36;
   localparam int FIXV  = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] dwell = 8'd2;
   logic       touch_en = 1'b1;
   logic [3:0] xpose = 4'd0;
   logic [7:0] scan_o, first_i, second_i;
   logic       ev_valid, ev_ready = 1'b1, ev_on, ovf;
   logic [6:0] ev_note, ev_vel;

   logic kf [64];
   logic ks [64];

   int n_ev = 0;
   int log_on [512];
   int log_note [512];
   int log_vel [512];
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   velkey_scanner #(.TMR_W(TMR_W), .DEPTH(4), .BASE_NOTE(BASE), .FIXED_VEL(FIXV)) u_velkey_scanner (
      .clk(clk), .rst_n(rst_n), .dwell_i(dwell), .touch_en_i(touch_en), .xpose_i(xpose),
      .scan_o(scan_o), .first_i(first_i), .second_i(second_i),
      .ev_valid_o(ev_valid), .ev_ready_i(ev_ready), .ev_on_o(ev_on),
      .ev_note_o(ev_note), .ev_vel_o(ev_vel), .ovf_o(ovf)
   );

   always_comb begin
      int c;
      c = 0;
      for (int i = 0; i < 8; i++) if (scan_o[i]) c = i;
      for (int r = 0; r < 8; r++) begin
         first_i[r]  = kf[c*8 + r];
         second_i[r] = ks[c*8 + r];
      end
   end

   always @(negedge clk) begin
      if (rst_n && ev_valid && ev_ready && n_ev < 512) begin
         log_on[n_ev]   = int'(ev_on);
         log_note[n_ev] = int'(ev_note);
         log_vel[n_ev]  = int'(ev_vel);
         n_ev = n_ev + 1;
      end
   end

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
      end
   endtask

   function automatic int opp(input int k);
      return ((k / 8) + 4) % 8;
   endfunction

   task automatic go_col(input int c);
      @(negedge clk);
      while (scan_o == (8'b1 << c)) @(negedge clk);
      while (scan_o != (8'b1 << c)) @(negedge clk);
   endtask

   task automatic press(input int k, input int r);
      go_col(opp(k));
      kf[k] = 1'b1;
      for (int i = 0; i < r; i++) go_col(opp(k));
      ks[k] = 1'b1;
      go_col(opp(k));
   endtask

   task automatic release_key(input int k);
      go_col(opp(k));
      kf[k] = 1'b0;
      ks[k] = 1'b0;
      go_col(opp(k));
   endtask

   task automatic chk_evt(input int base, input int on, input int note, input int vel, input string tag);
      chk(n_ev == base + 1, {tag, " event count"}, n_ev - base, 1);
      chk(log_on[base] == on, {tag, " on flag"}, log_on[base], on);
      chk(log_note[base] == note, {tag, " note"}, log_note[base], note);
      chk(log_vel[base] == vel, {tag, " vel"}, log_vel[base], vel);
   endtask

   function automatic int clampx(input int x);
      return (x < -6) ? -6 : ((x > 5) ? 5 : x);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int b, p, prev, nx, ev, t;
      for (int i = 0; i < 64; i++) begin kf[i] = 1'b0; ks[i] = 1'b0; end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      chk(scan_o == 8'h01, "R10 column 0 after reset", int'(scan_o), 1);
      chk(ev_valid == 1'b0, "R10 queue empty", int'(ev_valid), 0);
      chk(ovf == 1'b0, "R10 overflow clear", int'(ovf), 0);

      // R1 column timing and order
      for (int d = 0; d < 2; d++) begin
         int want;
         want = (d == 0) ? 11 : 14;
         prev = int'(scan_o);
         while (int'(scan_o) == prev) @(negedge clk);
         dwell = (d == 0) ? 8'd2 : 8'd5;
         prev = int'(scan_o);
         while (int'(scan_o) == prev) @(negedge clk);
         prev = int'(scan_o);
         p = 0;
         do begin @(negedge clk); p++; end while (int'(scan_o) == prev);
         nx = (prev == 128) ? 1 : prev * 2;
         chk(p == want, "R1 column hold clocks", p, want);
         chk(int'(scan_o) == nx, "R1 next column", int'(scan_o), nx);
         chk($countones(scan_o) == 1, "R1 one line active", $countones(scan_o), 1);
      end
      prev = int'(scan_o);
      while (int'(scan_o) == prev) @(negedge clk);
      dwell = 8'd2;

      // R2 R5 R6 every key, no transpose
      for (int k = 0; k < 61; k++) begin
         b = n_ev;
         press(k, 1);
         chk_evt(b, 1, BASE + k, 127, $sformatf("R2 key %0d on", k));
         b = n_ev;
         release_key(k);
         chk_evt(b, 0, BASE + k, 0, $sformatf("R6 key %0d off", k));
      end

      // R2 empty slots
      b = n_ev;
      for (int k = 61; k < 64; k++) press(k, 1);
      for (int k = 61; k < 64; k++) release_key(k);
      chk(n_ev == b, "R2 empty slots silent", n_ev - b, 0);

      // R3 velocity sweep
      for (int r = 1; r <= 18; r++) begin
         b = n_ev;
         press(10, r);
         t = (r - 1 > TMAX) ? TMAX : r - 1;
         ev = (t >= TMAX) ? 1 : 127 - t;
         chk_evt(b, 1, BASE + 10, ev, $sformatf("R3 scans=%0d", r));
         release_key(10);
      end

      // R4 touch response off
      touch_en = 1'b0;
      for (int r = 1; r <= 9; r += 4) begin
         b = n_ev;
         press(17, r);
         chk_evt(b, 1, BASE + 17, FIXV, $sformatf("R4 fixed vel scans=%0d", r));
         release_key(17);
      end
      touch_en = 1'b1;

      // R5 transpose incl. clamping
      for (int x = -8; x <= 7; x += 3) begin
         xpose = 4'(x);
         b = n_ev;
         press(20, 1);
         chk_evt(b, 1, BASE + 20 + clampx(x), 127, $sformatf("R5 xpose %0d on", x));
         b = n_ev;
         release_key(20);
         chk_evt(b, 0, BASE + 20 + clampx(x), 0, $sformatf("R5 xpose %0d off", x));
      end
      xpose = 4'd7;
      b = n_ev;
      press(0, 1);
      chk_evt(b, 1, BASE + 5, 127, "R5 xpose +7 clamps");
      release_key(0);
      xpose = 4'd0;

      // R7 early contact opens first: silent
      b = n_ev;
      go_col(opp(30));
      kf[30] = 1'b1;
      go_col(opp(30));
      go_col(opp(30));
      kf[30] = 1'b0;
      go_col(opp(30));
      go_col(opp(30));
      chk(n_ev == b, "R7 aborted stroke silent", n_ev - b, 0);

      // R7 late contact bounce while held
      press(30, 2);
      b = n_ev;
      ks[30] = 1'b0;
      go_col(opp(30));
      ks[30] = 1'b1;
      go_col(opp(30));
      ks[30] = 1'b0;
      go_col(opp(30));
      chk(n_ev == b, "R7 late contact bounce silent", n_ev - b, 0);
      release_key(30);
      chk_evt(b, 0, BASE + 30, 0, "R6 off after late contact opened");

      // R8 R9 overflow with one column of eight keys
      ev_ready = 1'b0;
      go_col(4);
      for (int k = 0; k < 8; k++) kf[k] = 1'b1;
      go_col(4);
      for (int k = 0; k < 8; k++) ks[k] = 1'b1;
      go_col(4);
      chk(ovf == 1'b1, "R9 overflow flag", int'(ovf), 1);
      b = n_ev;
      ev_ready = 1'b1;
      repeat (8) @(negedge clk);
      chk(n_ev == b + 4, "R8 queue holds DEPTH", n_ev - b, 4);
      for (int i = 0; i < 4; i++) begin
         chk(log_note[b+i] == BASE + i, $sformatf("R8 order %0d", i), log_note[b+i], BASE + i);
         chk(log_on[b+i] == 1, $sformatf("R8 kind %0d", i), log_on[b+i], 1);
      end
      b = n_ev;
      go_col(4);
      for (int k = 0; k < 8; k++) begin kf[k] = 1'b0; ks[k] = 1'b0; end
      go_col(4);
      chk(n_ev == b + 8, "R6 eight note-offs", n_ev - b, 8);
      for (int i = 0; i < 8; i++)
         chk(log_note[b+i] == BASE + i && log_on[b+i] == 0, $sformatf("R8 off order %0d", i), log_note[b+i], BASE + i);
      chk(ovf == 1'b1, "R9 flag sticky", int'(ovf), 1);

      // R10 reset clears flag
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk(ovf == 1'b0, "R10 flag cleared by reset", int'(ovf), 0);
      chk(scan_o == 8'h01, "R10 column 0 after second reset", int'(scan_o), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule